// File: doc/BRIEF.md
# Nibble Pixel Memory with Write Priority

This unit sits in front of a small pixel memory in which each 16-bit word packs four 4-bit pixels. A CPU-side port issues byte or word reads and writes using byte addresses, and each byte address names exactly one pixel. The unit turns each pixel write into a read-modify-write of the nibble it names. A per-request two-bit priority mode decides whether that nibble is replaced.

In plain mode every write lands. In overwrite mode a zero pixel is treated as transparent and leaves the stored pixel as it is. In underwrite mode a pixel lands only when it is nonzero and the stored pixel is zero, so earlier drawing stays on top. Reads return pixels unpacked, one per byte lane, with the upper nibble of each byte held at zero. The memory is an internal synchronous array.

Every request takes two cycles. In the first cycle the word is read. In the second cycle the word is conditionally written, or the read response is produced. `req_ready` is low during the second cycle, so a new request cannot be taken while the previous one is still in flight.

Top module: `pixpri_unit`

## Requirements
- R1: While reset is high and in the first cycle after reset, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is then 0 for exactly one cycle. For a read, `rsp_valid` pulses for one cycle, starting after the second edge following acceptance. A write produces no response.
- R3: Byte address A maps to word A>>2. Let k = A mod 4; the pixel occupies bits [15-4k:12-4k] of that word. A byte write uses only `req_wdata[3:0]` as the pixel value.
- R4: When `req_mode` is 2'b00 or 2'b11 (plain), every pixel write replaces the stored pixel, including zero values.
- R5: When `req_mode` is 2'b10 (overwrite), a pixel write with value zero is dropped. A nonzero value replaces the stored pixel.
- R6: When `req_mode` is 2'b01 (underwrite), a pixel write is dropped if the new value is zero or the stored pixel is nonzero.
- R7: A word write (`req_word`=1) ignores address bit 0. It writes `req_wdata[11:8]` to pixel A and `req_wdata[3:0]` to pixel A+1. Each of the two pixels is judged by the priority rule on its own.
- R8: A word read with address bit 1 clear returns pixel k=0 in `rsp_rdata[11:8]` and pixel k=1 in `rsp_rdata[3:0]`. With bit 1 set, it returns pixels k=2 and k=3 in those same positions. All other bits are zero.
- R9: A byte read returns the addressed pixel in `rsp_rdata[3:0]`, with `rsp_rdata[15:4]` zero. This matches the low byte of the word read for an odd address and the high byte for an even address.
- R10: A write never changes any pixel other than the one or two it addresses.
- R11: A request presented while `req_ready` is 0 is ignored and leaves the memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| req_addr | input | ADDR_W | Byte (pixel) address |
| req_wdata | input | 16 | Write data |
| req_mode | input | 2 | Priority: 00/11 plain, 10 overwrite, 01 underwrite |
| rsp_valid | output | 1 | Read data valid (one-cycle pulse) |
| rsp_rdata | output | 16 | Unpacked read data |

## Verification
The assertions check the handshake shape on every cycle: one busy cycle after each acceptance, a response exactly two edges after a read is accepted and never after a write, zero upper nibbles in every response, and memory writes only in the cycle after an accepted request. Whether a pixel write was kept or dropped under each priority mode can only be seen through the bench's scenarios. The bench reads pixels back and compares them with a pixel-level model. That model covers transparent zeros, underwrite onto occupied pixels, split word writes where one half is dropped, and requests made while the unit is busy.

// File: rtl/pixpri_pkg.sv
package pixpri_pkg;
  localparam int PIX_W        = 4;
  localparam int PIX_PER_WORD = 4;
  localparam int WORD_W       = PIX_W * PIX_PER_WORD;
  localparam int POS_W        = $clog2(PIX_PER_WORD);

  typedef enum logic [1:0] {
    PRI_PLAIN = 2'b00,
    PRI_UNDER = 2'b01,
    PRI_OVER  = 2'b10,
    PRI_BOTH  = 2'b11
  } pri_mode_e;

  // Decide whether a new pixel value may replace the stored one.
  function automatic logic pixel_commit(input pri_mode_e m,
                                        input logic [PIX_W-1:0] nv,
                                        input logic [PIX_W-1:0] ov);
    logic ok;
    case (m)
      PRI_OVER:  ok = (nv != '0);
      PRI_UNDER: ok = (nv != '0) && (ov == '0);
      default:   ok = 1'b1;
    endcase
    return ok;
  endfunction
endpackage

// File: rtl/pixpri_store.sv
module pixpri_store #(
  parameter int IDX_W  = 8,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [WORD_W-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pixpri_merge.sv
module pixpri_merge
  import pixpri_pkg::*;
(
  input  logic [WORD_W-1:0] old_word,
  input  pri_mode_e         mode,
  input  logic              l0_en,
  input  logic [POS_W-1:0]  l0_pos,
  input  logic [PIX_W-1:0]  l0_val,
  input  logic              l1_en,
  input  logic [POS_W-1:0]  l1_pos,
  input  logic [PIX_W-1:0]  l1_val,
  output logic [WORD_W-1:0] new_word,
  output logic              any_take
);
  logic [PIX_PER_WORD-1:0] slot_take;

  for (genvar s = 0; s < PIX_PER_WORD; s++) begin : g_slot
    localparam int HI = WORD_W - 1 - PIX_W * s;
    localparam logic [POS_W-1:0] SLOT = POS_W'(s);
    logic             h0, h1, take;
    logic [PIX_W-1:0] ov, nv;
    assign ov   = old_word[HI -: PIX_W];
    assign h0   = l0_en && (l0_pos == SLOT);
    assign h1   = l1_en && (l1_pos == SLOT);
    assign nv   = h0 ? l0_val : l1_val;
    assign take = (h0 || h1) && pixel_commit(mode, nv, ov);
    assign new_word[HI -: PIX_W] = take ? nv : ov;
    assign slot_take[s] = take;
  end

  assign any_take = |slot_take;
endmodule

// File: rtl/pixpri_unpack.sv
module pixpri_unpack
  import pixpri_pkg::*;
(
  input  logic [WORD_W-1:0] word_in,
  input  logic [POS_W-1:0]  pos,
  input  logic              is_word,
  output logic [WORD_W-1:0] data_out
);
  logic [PIX_W-1:0] hi_pix, lo_pix, one_pix;

  always_comb begin
    hi_pix  = pos[1] ? word_in[WORD_W-1-2*PIX_W -: PIX_W] : word_in[WORD_W-1 -: PIX_W];
    lo_pix  = pos[1] ? word_in[WORD_W-1-3*PIX_W -: PIX_W] : word_in[WORD_W-1-PIX_W -: PIX_W];
    one_pix = word_in[WORD_W-1-PIX_W*int'(pos) -: PIX_W];
    if (is_word)
      data_out = {{(8-PIX_W){1'b0}}, hi_pix, {(8-PIX_W){1'b0}}, lo_pix};
    else
      data_out = {{(WORD_W-PIX_W){1'b0}}, one_pix};
  end
endmodule

// File: rtl/pixpri_unit.sv
module pixpri_unit
  import pixpri_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic              req_word,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic [1:0]        req_mode,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_rdata
);
  localparam int IDX_W = ADDR_W - POS_W;

  typedef enum logic {ST_IDLE, ST_MERGE} st_e;
  st_e st;

  logic              acc;
  logic              op_we, op_word;
  logic [ADDR_W-1:0] op_addr;
  logic [WORD_W-1:0] op_data;
  pri_mode_e         op_mode;
  logic [WORD_W-1:0] rd_word, new_word, rd_unpacked;
  logic              any_take, store_we;
  logic [POS_W-1:0]  l0_pos, l1_pos;
  logic [PIX_W-1:0]  l0_val;

  assign acc = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      req_ready <= 1'b1;
      op_we     <= 1'b0;
      op_word   <= 1'b0;
      op_addr   <= '0;
      op_data   <= '0;
      op_mode   <= PRI_PLAIN;
    end else if (st == ST_IDLE) begin
      if (acc) begin
        st        <= ST_MERGE;
        req_ready <= 1'b0;
        op_we     <= req_we;
        op_word   <= req_word;
        op_addr   <= req_addr;
        op_data   <= req_wdata;
        op_mode   <= pri_mode_e'(req_mode);
      end
    end else begin
      st        <= ST_IDLE;
      req_ready <= 1'b1;
    end
  end

  pixpri_store #(.IDX_W(IDX_W), .WORD_W(WORD_W)) u_store (
    .clk   (clk),
    .we    (store_we),
    .waddr (op_addr[ADDR_W-1:POS_W]),
    .wdata (new_word),
    .raddr (req_addr[ADDR_W-1:POS_W]),
    .rdata (rd_word)
  );

  // Word accesses cover an even/odd pixel pair; bit 0 is dropped.
  assign l0_pos = op_word ? {op_addr[POS_W-1:1], 1'b0} : op_addr[POS_W-1:0];
  assign l1_pos = {op_addr[POS_W-1:1], 1'b1};
  assign l0_val = op_word ? op_data[8 +: PIX_W] : op_data[0 +: PIX_W];

  pixpri_merge u_merge (
    .old_word (rd_word),
    .mode     (op_mode),
    .l0_en    (1'b1),
    .l0_pos   (l0_pos),
    .l0_val   (l0_val),
    .l1_en    (op_word),
    .l1_pos   (l1_pos),
    .l1_val   (op_data[0 +: PIX_W]),
    .new_word (new_word),
    .any_take (any_take)
  );

  assign store_we = (st == ST_MERGE) && op_we && any_take;

  pixpri_unpack u_unpack (
    .word_in  (rd_word),
    .pos      (op_addr[POS_W-1:0]),
    .is_word  (op_word),
    .data_out (rd_unpacked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= (st == ST_MERGE) && !op_we;
      if ((st == ST_MERGE) && !op_we) rsp_rdata <= rd_unpacked;
    end
  end
endmodule

// File: rtl/pixpri_unit_chk.sv
module pixpri_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_we,
  input logic        rsp_valid,
  input logic [15:0] rsp_rdata,
  input logic        store_we
);
  logic rd_acc, any_acc;
  assign any_acc = req_valid && req_ready;
  assign rd_acc  = any_acc && !req_we;

  // R2: one busy cycle after each acceptance
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    any_acc |=> !req_ready);

  // R2: busy never lasts more than one cycle
  a_r2_single_busy: assert property (@(posedge clk) disable iff (rst)
    !req_ready |=> req_ready);

  // R2: a read response follows two edges after a read is taken
  a_r2_read_responds: assert property (@(posedge clk) disable iff (rst)
    rd_acc |-> ##2 rsp_valid);

  // R2: no response without a read two edges earlier
  a_r2_no_stray_rsp: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(rd_acc, 2));

  // R9: unpacked pixels leave upper nibbles at zero
  a_r9_upper_zero: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_rdata[15:12] == 4'h0 && rsp_rdata[7:4] == 4'h0));

  // R11: memory is written only right after an accepted request
  a_r11_write_follows_accept: assert property (@(posedge clk) disable iff (rst)
    store_we |-> $past(any_acc && req_we));
endmodule

bind pixpri_unit pixpri_unit_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_we    (req_we),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata),
  .store_we  (store_we)
);

// File: tb/tb_pixpri_unit.sv
module tb_pixpri_unit;
  localparam int ADDR_W = 10;
  localparam int NPIX   = 64;

  logic              clk = 1'b0;
  logic              rst;
  logic              req_valid, req_we, req_word;
  logic              req_ready, rsp_valid;
  logic [ADDR_W-1:0] req_addr;
  logic [15:0]       req_wdata, rsp_rdata;
  logic [1:0]        req_mode;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [3:0] pix [0:NPIX-1];

  always #2 clk = ~clk;

  pixpri_unit #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_word(req_word), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_mode(req_mode),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit commit(input logic [1:0] m, input logic [3:0] nv, input logic [3:0] ov);
    if (m == 2'b10) return nv != 0;
    if (m == 2'b01) return nv != 0 && ov == 0;
    return 1'b1;
  endfunction

  task automatic mpix(input int a, input logic [3:0] v, input logic [1:0] m);
    if (commit(m, v, pix[a])) pix[a] = v;
  endtask

  task automatic mwrite(input bit word, input int a, input logic [15:0] d, input logic [1:0] m);
    if (word) begin
      mpix(a & ~1, d[11:8], m);
      mpix((a & ~1) + 1, d[3:0], m);
    end else mpix(a, d[3:0], m);
  endtask

  function automatic logic [15:0] exp_rd(input bit word, input int a);
    int b;
    if (word) begin
      b = (a & ~3) + (((a >> 1) & 1) * 2);
      return {4'h0, pix[b], 4'h0, pix[b+1]};
    end
    return {12'h000, pix[a]};
  endfunction

  // Called at a falling edge; returns at a falling edge.
  task automatic op(input bit we, input bit word, input int a, input logic [15:0] d,
                    input logic [1:0] m, input bit hold, input string tag);
    logic [15:0] e;
    chk(req_ready === 1'b1, "R2 ready idle", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_we = we; req_word = word;
    req_addr = ADDR_W'(a); req_wdata = d; req_mode = m;
    e = exp_rd(word, a);
    @(negedge clk);
    chk(req_ready === 1'b0, "R2 busy", 32'(req_ready), 32'd0);
    if (hold) begin
      // R11: a write offered while busy must be ignored
      req_we = 1'b1; req_word = 1'b1; req_mode = 2'b00;
      req_addr = ADDR_W'(a); req_wdata = 16'h0F0F ^ d;
    end else req_valid = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    if (we) mwrite(word, a, d, m);
    chk(rsp_valid === !we, {tag, " rsp_valid"}, 32'(rsp_valid), 32'(!we));
    if (!we) chk(rsp_rdata === e, tag, 32'(rsp_rdata), 32'(e));
    chk(req_ready === 1'b1, "R2 ready back", 32'(req_ready), 32'd1);
  endtask

  function automatic logic [3:0] rnib();
    return ($urandom_range(0, 9) < 4) ? 4'h0 : 4'($urandom_range(1, 15));
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1'b1; req_valid = 0; req_we = 0; req_word = 0;
    req_addr = '0; req_wdata = '0; req_mode = '0;
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1 && rsp_valid === 1'b0, "R1 in reset", {req_ready, rsp_valid}, 32'b10);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready === 1'b1 && rsp_valid === 1'b0, "R1 after reset", {req_ready, rsp_valid}, 32'b10);

    for (int a = 0; a < NPIX; a += 2) op(1, 1, a, 16'h0000, 2'b00, 0, "init");

    // R3 placement and low-nibble use
    op(1, 0, 5, 16'h00A7, 2'b00, 0, "R3");
    op(0, 0, 5, 0, 0, 0, "R3 byte readback");
    op(0, 1, 4, 0, 0, 0, "R3 word readback");
    // R10 neighbour pixels intact
    op(1, 0, 4, 16'h0003, 2'b00, 0, "R10");
    op(0, 1, 6, 0, 0, 0, "R10 other half");
    op(0, 0, 5, 0, 0, 0, "R10 neighbour");
    // R4 plain with mode 11 writes zero
    op(1, 0, 5, 16'h0000, 2'b11, 0, "R4");
    op(0, 0, 5, 0, 0, 0, "R4 zero landed");
    // R5 overwrite
    op(1, 0, 6, 16'h0009, 2'b00, 0, "R5 setup");
    op(1, 0, 6, 16'h0000, 2'b10, 0, "R5");
    op(0, 0, 6, 0, 0, 0, "R5 zero dropped");
    op(1, 0, 6, 16'h0003, 2'b10, 0, "R5");
    op(0, 0, 6, 0, 0, 0, "R5 nonzero landed");
    // R6 underwrite
    op(1, 0, 6, 16'h0005, 2'b01, 0, "R6");
    op(0, 0, 6, 0, 0, 0, "R6 occupied kept");
    op(1, 0, 6, 16'h0000, 2'b00, 0, "R6 clear");
    op(1, 0, 6, 16'h0000, 2'b01, 0, "R6");
    op(1, 0, 6, 16'h000C, 2'b01, 0, "R6");
    op(0, 0, 6, 0, 0, 0, "R6 empty filled");
    // R7 word writes, bit 0 ignored, halves judged separately
    op(1, 1, 9, 16'h0A0B, 2'b00, 0, "R7");
    op(0, 0, 8, 0, 0, 0, "R7 high byte");
    op(0, 0, 9, 0, 0, 0, "R7 low byte");
    op(1, 1, 8, 16'h0005, 2'b10, 0, "R7");
    op(0, 1, 8, 0, 0, 0, "R7 split");
    op(1, 1, 10, 16'h0700, 2'b01, 0, "R7");
    // R8 / R9 read formats
    op(0, 1, 10, 0, 0, 0, "R8 upper half off");
    op(0, 1, 11, 0, 0, 0, "R8 bit0 ignored");
    op(0, 0, 10, 0, 0, 0, "R9 even");
    op(0, 0, 11, 0, 0, 0, "R9 odd");
    // R11 busy request ignored
    op(1, 0, 12, 16'h0001, 2'b00, 1, "R11");
    op(0, 1, 12, 0, 0, 1, "R11 readback");
    op(0, 1, 14, 0, 0, 0, "R11 other half");

    for (int i = 0; i < 400; i++) begin
      automatic bit we   = $urandom_range(0, 1) == 1;
      automatic bit word = $urandom_range(0, 1) == 1;
      automatic int a    = $urandom_range(0, NPIX - 1);
      automatic logic [15:0] d = {4'($urandom), rnib(), 4'($urandom), rnib()};
      op(we, word, a, d, 2'($urandom_range(0, 3)), $urandom_range(0, 3) == 0,
         word ? "R8 random" : "R9 random");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule